// File: doc/BRIEF.md
# Charger Port Detection Sequencer

This block sits in a battery-powered device and decides what kind of upstream port the device has been plugged into, then tells the charger how much input current it may draw. It reads digitized results from an analog detection front end: bus power present, data-pin contact, and the outputs of the primary and secondary detection comparators. It also reads the enumeration and suspend status from the device controller. It drives a one-cycle start pulse for each detection phase, the detected port kind, a 3-bit current ceiling code, and a signal that hands the data lines over to the USB transceiver.

The sequencer is a five-state machine. ST_IDLE waits for bus power. ST_DCD waits for data-pin contact. ST_PRI tells a plain standard port apart from a charging-capable one. ST_SEC tells a charging host port apart from a dedicated charger. ST_DONE holds the result. The named transitions are:
- T_ATTACH: ST_IDLE to ST_DCD.
- T_CONTACT: ST_DCD to ST_PRI.
- T_DCD_TMO: ST_DCD to ST_DONE.
- T_PRI_STD: ST_PRI to ST_DONE, when the comparator reports a plain port.
- T_PRI_CHG: ST_PRI to ST_SEC, when the comparator reports a charging-capable port.
- T_PRI_TMO: ST_PRI to ST_DONE.
- T_SEC_RES: ST_SEC to ST_DONE.
- T_SEC_TMO: ST_SEC to ST_DONE.
- T_DETACH: any state to ST_IDLE.

Each comparator result must stay unchanged for DBNC_CYC samples before it is accepted. Each phase gives up after TMO_CYC cycles.

Top module: `chg_port_seq`

## Requirements
- R1: After reset, and while `vbus_ok` is low, the sequencer stays in ST_IDLE with `port_kind`=0 (unknown), `ilim_code`=0, `xcvr_own`=0 and all three start pulses low. Port kind codes are 0 unknown, 1 standard port, 2 charging host port and 3 dedicated charger.
- R2: In ST_IDLE a high `vbus_ok` takes T_ATTACH. `dcd_start` is high for exactly one cycle, the first cycle of ST_DCD (one cycle after the edge that samples `vbus_ok`). At most one start pulse is high in any cycle.
- R3: In ST_DCD, once `dcd_hit` has been sampled high on DBNC_CYC consecutive edges, the next edge takes T_CONTACT. A held contact therefore keeps ST_DCD for DBNC_CYC+1 cycles. `pri_start` pulses for one cycle on entry to ST_PRI.
- R4: If contact is not accepted within TMO_CYC+1 cycles of ST_DCD, T_DCD_TMO ends detection as a standard port (kind 1). Neither `pri_start` nor `sec_start` pulses.
- R5: In ST_PRI, an accepted `pri_cmp`=0 takes T_PRI_STD and gives kind 1. An accepted `pri_cmp`=1 takes T_PRI_CHG, and `sec_start` pulses on entry to ST_SEC. Secondary detection runs only after T_PRI_CHG.
- R6: In ST_SEC, an accepted `sec_cmp`=1 gives kind 3 (dedicated charger) and an accepted `sec_cmp`=0 gives kind 2 (charging host port), both through T_SEC_RES.
- R7: A comparator result is accepted only after DBNC_CYC identical consecutive samples. A primary or secondary result that never settles for that long takes the phase timeout after TMO_CYC+1 cycles and gives kind 1.
- R8: `xcvr_own` rises with entry to ST_DONE for kinds 1 and 2. It is never high for kind 3.
- R9: Current codes are 0 = 2.5 mA, 1 = 100 mA, 2 = 500 mA and 3 = 1.5 A. While detection runs (ST_DCD, ST_PRI, ST_SEC) the code is 1.
- R10: In ST_DONE with kind 1, the code is 0 when `susp` is high, otherwise 2 when `enum_done` is high, otherwise 1. With kind 2 or 3 the code is 3.
- R11: A low `vbus_ok` in any state takes T_DETACH. `port_kind` and `xcvr_own` clear one cycle after it is sampled, and `ilim_code` reaches 0 one cycle after that.
- R12: `ilim_code` is registered. It shows the value selected by the state, kind and status inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbus_ok | input | 1 | Bus power valid |
| dcd_hit | input | 1 | Data-pin contact seen by the front end |
| pri_cmp | input | 1 | Primary comparator: 1 = charging-capable port |
| sec_cmp | input | 1 | Secondary comparator: 1 = dedicated charger |
| enum_done | input | 1 | Device enumerated and power negotiated |
| susp | input | 1 | Device suspended |
| dcd_start | output | 1 | Start pulse for the contact detection phase |
| pri_start | output | 1 | Start pulse for the primary detection phase |
| sec_start | output | 1 | Start pulse for the secondary detection phase |
| port_kind | output | 2 | Detected port kind (see R1) |
| ilim_code | output | 3 | Input current ceiling code (see R9) |
| xcvr_own | output | 1 | Data lines handed to the transceiver |

## Verification
The hardest case to reach from the ports is a comparator that chatters for a whole phase. Every sample differs from the previous one, so the debounce counter keeps restarting and only the phase timer ends the phase. The stimulus reaches this by toggling `pri_cmp` on every falling edge once contact is held. The expected completion cycle, DBNC_CYC+TMO_CYC+3 edges after attach, is computed in the bench. The sweep covers every combination of contact, primary result, secondary result and chatter. For each combination it checks the cycle of every start pulse, the latency to a result, and the current code under each suspend and enumeration pairing.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DCD  = 3'd1,
        ST_PRI  = 3'd2,
        ST_SEC  = 3'd3,
        ST_DONE = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_STD  = 2'd1,
        PK_CHG  = 2'd2,
        PK_DED  = 2'd3
    } port_kind_e;

    localparam logic [2:0] IL_SUSP = 3'd0;
    localparam logic [2:0] IL_100  = 3'd1;
    localparam logic [2:0] IL_500  = 3'd2;
    localparam logic [2:0] IL_1A5  = 3'd3;

endpackage

// File: rtl/chg_dbnc.sv
module chg_dbnc #(
    parameter int DBNC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    output logic ok,
    output logic val
);
    localparam int CW = $clog2(DBNC_CYC + 1);

    logic [CW-1:0] run_q;
    logic          last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (clr) begin
            run_q  <= '0;
        end else if (run_q == '0 || smp != last_q) begin
            run_q  <= CW'(1);
            last_q <= smp;
        end else if (run_q != CW'(DBNC_CYC)) begin
            run_q  <= run_q + CW'(1);
        end
    end

    assign ok  = (run_q == CW'(DBNC_CYC));
    assign val = last_q;

    AST_DBNC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(DBNC_CYC)); // R7

endmodule

// File: rtl/chg_phase_timer.sv
module chg_phase_timer #(
    parameter int TMO_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tmo
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(TMO_CYC)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tmo = (cnt_q == CW'(TMO_CYC));

    AST_TMR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TMO_CYC)); // R4

endmodule

// File: rtl/chg_ilim_map.sv
module chg_ilim_map
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_st_e    st,
    input  port_kind_e kind,
    input  logic       susp,
    input  logic       enum_done,
    output logic [2:0] ilim_q
);
    logic [2:0] ilim_nx;

    always_comb begin
        ilim_nx = IL_100;
        unique case (st)
            ST_IDLE: ilim_nx = IL_SUSP;
            ST_DCD, ST_PRI, ST_SEC: ilim_nx = IL_100;
            ST_DONE: begin
                unique case (kind)
                    PK_STD:  ilim_nx = susp ? IL_SUSP : (enum_done ? IL_500 : IL_100);
                    PK_CHG,
                    PK_DED:  ilim_nx = IL_1A5;
                    default: ilim_nx = IL_100;
                endcase
            end
            default: ilim_nx = IL_SUSP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ilim_q <= IL_SUSP;
        else        ilim_q <= ilim_nx;
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (ilim_q == IL_SUSP)); // R11
    AST_DET_100: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DCD || st == ST_PRI || st == ST_SEC) |=> (ilim_q == IL_100)); // R9

endmodule

// File: rtl/chg_port_seq.sv
module chg_port_seq
    import chg_seq_pkg::*;
#(
    parameter int DBNC_CYC = 4,
    parameter int TMO_CYC  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_ok,
    input  logic       dcd_hit,
    input  logic       pri_cmp,
    input  logic       sec_cmp,
    input  logic       enum_done,
    input  logic       susp,
    output logic       dcd_start,
    output logic       pri_start,
    output logic       sec_start,
    output logic [1:0] port_kind,
    output logic [2:0] ilim_code,
    output logic       xcvr_own
);
    seq_st_e    st_q, st_nx;
    port_kind_e kind_q, kind_nx;
    logic       db_smp, db_ok, db_val, tmo, ph_clr;

    // comparator input for the active phase
    always_comb begin
        unique case (st_q)
            ST_DCD:  db_smp = dcd_hit;
            ST_PRI:  db_smp = pri_cmp;
            ST_SEC:  db_smp = sec_cmp;
            default: db_smp = 1'b0;
        endcase
    end

    // next state and result
    always_comb begin
        st_nx   = st_q;
        kind_nx = kind_q;
        if (!vbus_ok) begin
            st_nx   = ST_IDLE;                       // T_DETACH
            kind_nx = PK_NONE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_nx = ST_DCD;             // T_ATTACH
                ST_DCD: begin
                    if (db_ok && db_val) begin
                        st_nx = ST_PRI;              // T_CONTACT
                    end else if (tmo) begin
                        st_nx   = ST_DONE;           // T_DCD_TMO
                        kind_nx = PK_STD;
                    end
                end
                ST_PRI: begin
                    if (db_ok && db_val) begin
                        st_nx = ST_SEC;              // T_PRI_CHG
                    end else if (db_ok || tmo) begin
                        st_nx   = ST_DONE;           // T_PRI_STD / T_PRI_TMO
                        kind_nx = PK_STD;
                    end
                end
                ST_SEC: begin
                    if (db_ok) begin
                        st_nx   = ST_DONE;           // T_SEC_RES
                        kind_nx = db_val ? PK_DED : PK_CHG;
                    end else if (tmo) begin
                        st_nx   = ST_DONE;           // T_SEC_TMO
                        kind_nx = PK_STD;
                    end
                end
                ST_DONE: st_nx = ST_DONE;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    assign ph_clr = (st_nx != st_q);

    chg_dbnc #(.DBNC_CYC(DBNC_CYC)) i_dbnc (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .smp(db_smp),
        .ok(db_ok), .val(db_val)
    );

    chg_phase_timer #(.TMO_CYC(TMO_CYC)) i_tmr (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .tmo(tmo)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= PK_NONE;
        end else begin
            st_q   <= st_nx;
            kind_q <= kind_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcd_start <= 1'b0;
            pri_start <= 1'b0;
            sec_start <= 1'b0;
            xcvr_own  <= 1'b0;
        end else begin
            dcd_start <= (st_nx == ST_DCD) && (st_q != ST_DCD);
            pri_start <= (st_nx == ST_PRI) && (st_q != ST_PRI);
            sec_start <= (st_nx == ST_SEC) && (st_q != ST_SEC);
            xcvr_own  <= (st_nx == ST_DONE) && (kind_nx == PK_STD || kind_nx == PK_CHG);
        end
    end

    assign port_kind = kind_q;

    chg_ilim_map i_ilim (
        .clk(clk), .rst_n(rst_n), .st(st_q), .kind(kind_q),
        .susp(susp), .enum_done(enum_done), .ilim_q(ilim_code)
    );

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dcd_start, pri_start, sec_start}) <= 1); // R2
    AST_VBUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_ok |=> (port_kind == 2'd0 && !xcvr_own)); // R11
    AST_DED_NO_XCVR: assert property (@(posedge clk) disable iff (!rst_n)
        (port_kind == 2'd3) |-> !xcvr_own); // R8
    AST_SEC_AFTER_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        sec_start |-> ($past(st_q) == ST_PRI)); // R5
    AST_PRI_AFTER_DCD: assert property (@(posedge clk) disable iff (!rst_n)
        pri_start |-> ($past(st_q) == ST_DCD)); // R3

endmodule

// File: tb/test_chg_port_seq.sv
module test_chg_port_seq;
    localparam int CLK_PERIOD = 10;
    localparam int D = 3;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vbus_ok = 1'b0, dcd_hit = 1'b0, pri_cmp = 1'b0, sec_cmp = 1'b0;
    logic enum_done = 1'b0, susp = 1'b0;
    logic dcd_start, pri_start, sec_start, xcvr_own;
    logic [1:0] port_kind;
    logic [2:0] ilim_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_port_seq #(.DBNC_CYC(D), .TMO_CYC(T)) i_chg_port_seq (
        .clk(clk), .rst_n(rst_n), .vbus_ok(vbus_ok), .dcd_hit(dcd_hit),
        .pri_cmp(pri_cmp), .sec_cmp(sec_cmp), .enum_done(enum_done), .susp(susp),
        .dcd_start(dcd_start), .pri_start(pri_start), .sec_start(sec_start),
        .port_kind(port_kind), .ilim_code(ilim_code), .xcvr_own(xcvr_own)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input bit dh, input bit p, input bit s, input bit alt);
        int dcd_n = 0, pri_n = 0, sec_n = 0, kind_n = 0;
        int dcd_c = 0, pri_c = 0, sec_c = 0;
        int e_kind, e_lat, e_pri, e_sec, e_code;
        dcd_hit = dh; pri_cmp = p; sec_cmp = s; susp = 1'b0; enum_done = 1'b0;
        vbus_ok = 1'b1;
        for (int n = 1; n <= 60; n++) begin
            step();
            if (alt) pri_cmp = ~pri_cmp;
            if (dcd_start) begin dcd_c++; if (dcd_n == 0) dcd_n = n; end
            if (pri_start) begin pri_c++; if (pri_n == 0) pri_n = n; end
            if (sec_start) begin sec_c++; if (sec_n == 0) sec_n = n; end
            if (port_kind != 0 && kind_n == 0) kind_n = n;
            if (n == 1) chk("R12 ilim before detection", int'(ilim_code), 0);
            if (n == 2) chk("R9 ilim during detection", int'(ilim_code), 1);
        end
        if (!dh)      begin e_kind = 1; e_lat = T + 2;     e_pri = 0;     e_sec = 0;         end
        else if (alt) begin e_kind = 1; e_lat = D + T + 3; e_pri = D + 2; e_sec = 0;         end
        else if (!p)  begin e_kind = 1; e_lat = 2*D + 3;   e_pri = D + 2; e_sec = 0;         end
        else          begin e_kind = s ? 3 : 2; e_lat = 3*D + 4; e_pri = D + 2; e_sec = 2*D + 3; end
        chk("R2 dcd_start cycle", dcd_n, 1);
        chk("R2 dcd_start count", dcd_c, 1);
        chk("R3 pri_start cycle", pri_n, e_pri);
        chk("R3 pri_start count", pri_c, (e_pri != 0) ? 1 : 0);
        chk("R5 sec_start cycle", sec_n, e_sec);
        chk("R5 sec_start count", sec_c, (e_sec != 0) ? 1 : 0);
        chk(dh ? (alt ? "R7 chatter timeout latency" : "R6 result latency") : "R4 contact timeout latency",
            kind_n, e_lat);
        chk(s && p && dh && !alt ? "R6 port kind" : "R5 port kind", int'(port_kind), e_kind);
        chk("R8 handover", int'(xcvr_own), (e_kind == 3) ? 0 : 1);
        for (int c = 0; c < 4; c++) begin
            susp = c[1]; enum_done = c[0];
            step();
            if (e_kind == 1) e_code = c[1] ? 0 : (c[0] ? 2 : 1);
            else             e_code = 3;
            chk("R10 ilim code", int'(ilim_code), e_code);
        end
        vbus_ok = 1'b0;
        step();
        chk("R11 kind cleared", int'(port_kind), 0);
        chk("R11 handover cleared", int'(xcvr_own), 0);
        chk("R12 ilim lags state", int'(ilim_code), e_code);
        step();
        chk("R11 ilim lowest", int'(ilim_code), 0);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 5; n++) begin
            step();
            chk("R1 idle kind", int'(port_kind), 0);
            chk("R1 idle ilim", int'(ilim_code), 0);
            chk("R1 idle starts", int'({dcd_start, pri_start, sec_start, xcvr_own}), 0);
        end
        for (int dh = 0; dh < 2; dh++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++)
                    for (int alt = 0; alt < 2; alt++)
                        run_case(dh[0], p[0], s[0], alt[0]);
        // detach in the middle of primary detection
        dcd_hit = 1'b1; pri_cmp = 1'b1; sec_cmp = 1'b0; vbus_ok = 1'b1;
        repeat (D + 3) step();
        vbus_ok = 1'b0;
        step();
        chk("R11 mid-detection kind", int'(port_kind), 0);
        step();
        chk("R11 mid-detection ilim", int'(ilim_code), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule